// File: doc/BRIEF.md
# Character-Synchronous Transparent Frame Receiver

This block takes a serial bit stream, already recovered to one bit per `bit_en` strobe, that carries character-oriented frames, and returns the payload characters of each frame in parallel form. Out of reset, and again after the host raises `hunt_req`, it slides a window over the last eight received bits. It compares that window with the synchronising character 0x16 on every new bit. The first match fixes the character boundary. From then on the stream is cut into contiguous 8-bit characters that start with the bit after the match.

Once aligned, the block waits for the two-character opening sequence (escape 0x10, then 0x02). It passes each body character out with a one-cycle valid strobe. A doubled escape inside a body becomes one data byte of 0x10. The escape followed by 0x03 closes the frame. The two characters after the close are check characters. They are delivered together on a separate port and never appear as payload. Synchronising characters and any other characters between frames are treated as fill and dropped. An escape followed by an undefined code aborts the frame with an error strobe.

Top module: `char_sync_rx`

## Requirements
- R1: While not locked, when the last eight bits received (the newest bit included) equal 0x16, `locked` is 1 from the clock edge after the strobe that delivered that bit. Bits arrive least significant bit first, so 0x16 appears on the line as 0,1,1,0,1,0,0,0.
- R2: While locked, the stream is split into contiguous 8-bit characters starting with the bit after the match, first received bit in bit 0. `locked` stays 1 until `hunt_req`.
- R3: While `locked` is 0, `data_vld`, `frame_end`, `frame_err` and `chk_vld` stay 0, even if the stream contains escape and start codes.
- R4: Between frames, 0x16 and every character that does not begin the 0x10 0x02 pair produce no output.
- R5: After 0x10 0x02, each body character other than 0x10 is output on `data_out`, with one `data_vld` pulse per character, in order. 0x16 and a lone 0x03 inside a body are ordinary data.
- R6: Inside a body, 0x10 0x10 yields exactly one data byte of 0x10.
- R7: Inside a body, 0x10 0x03 gives one `frame_end` pulse and no data byte.
- R8: The two characters after 0x10 0x03 are not payload. They are presented as `chk_out`, with the first check character in bits 7:0 and the second in bits 15:8, together with one `chk_vld` pulse.
- R9: Inside a body, 0x10 followed by any code other than 0x10, 0x02 or 0x03 gives one `frame_err` pulse. Later characters produce no output until a new 0x10 0x02.
- R10: Inside a body, 0x10 0x02 drops the open frame without any strobe and starts a new frame.
- R11: `hunt_req` clears `locked` at the next clock edge, abandons any open frame without a strobe, and resumes bit-by-bit search.
- R12: At most one of `data_vld`, `frame_end`, `frame_err` and `chk_vld` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hunt_req | input | 1 | Drop alignment and search again |
| bit_en | input | 1 | Strobe: `bit_in` holds a new line bit |
| bit_in | input | 1 | Serial data bit |
| locked | output | 1 | Character alignment found |
| data_out | output | 8 | Payload character |
| data_vld | output | 1 | `data_out` valid for one cycle |
| frame_end | output | 1 | Closing sequence seen |
| frame_err | output | 1 | Frame aborted on an undefined escape |
| chk_out | output | 16 | Check characters, first in low byte |
| chk_vld | output | 1 | `chk_out` valid for one cycle |

## Verification
The bench builds the receiver with its defaults: 8-bit characters, LSB-first shifting, two check characters. That setting puts the transparency cases in reach: a doubled escape, 0x16 and a lone 0x03 inside a body, an undefined escape, a restarting start pair, and a hunt issued in mid-frame. Runs of pad bits before each synchronising character move the character boundary away from any multiple of eight. The bench therefore sees the search lock at arbitrary bit offsets, both at first lock and after a hunt.

// File: rtl/csr_pkg.sv
package csr_pkg;
   typedef enum logic [2:0] {
      ST_WAIT     = 3'd0,
      ST_WAIT_ESC = 3'd1,
      ST_BODY     = 3'd2,
      ST_BODY_ESC = 3'd3,
      ST_CHECK    = 3'd4
   } frm_st_t;
endpackage

// File: rtl/csr_bit_align.sv
module csr_bit_align #(
   parameter int unsigned   CHAR_W    = 8,
   parameter bit            LSB_FIRST = 1'b1,
   parameter logic [CHAR_W-1:0] SYNC_CODE = 8'h16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hunt_req,
   input  logic              bit_en,
   input  logic              bit_in,
   output logic              locked,
   output logic              char_vld,
   output logic [CHAR_W-1:0] char_dat
);
   localparam int unsigned CNT_W = (CHAR_W > 2) ? $clog2(CHAR_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);

   logic [CHAR_W-1:0] win_q;
   logic [CHAR_W-1:0] win_nxt;
   logic [CNT_W-1:0]  pos_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign win_nxt = {bit_in, win_q[CHAR_W-1:1]};
      end else begin : g_msb
         assign win_nxt = {win_q[CHAR_W-2:0], bit_in};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q    <= '0;
         pos_q    <= '0;
         locked   <= 1'b0;
         char_vld <= 1'b0;
         char_dat <= '0;
      end else begin
         char_vld <= 1'b0;
         if (bit_en) begin
            win_q <= win_nxt;
         end
         if (hunt_req) begin
            locked <= 1'b0;
            pos_q  <= '0;
         end else if (bit_en) begin
            if (!locked) begin
               if (win_nxt == SYNC_CODE) begin
                  locked <= 1'b1;
                  pos_q  <= '0;
               end
            end else if (pos_q == LAST_BIT) begin
               pos_q    <= '0;
               char_vld <= 1'b1;
               char_dat <= win_nxt;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/csr_deframe.sv
module csr_deframe
   import csr_pkg::*;
#(
   parameter int unsigned CHAR_W    = 8,
   parameter int unsigned CHK_CHARS = 2,
   parameter logic [CHAR_W-1:0] ESC_CODE = 8'h10,
   parameter logic [CHAR_W-1:0] SOF_CODE = 8'h02,
   parameter logic [CHAR_W-1:0] EOF_CODE = 8'h03
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        char_vld,
   input  logic [CHAR_W-1:0]           char_dat,
   output logic [CHAR_W-1:0]           data_out,
   output logic                        data_vld,
   output logic                        frame_end,
   output logic                        frame_err,
   output logic [CHAR_W*CHK_CHARS-1:0] chk_out,
   output logic                        chk_vld
);
   localparam int unsigned CHK_BITS = CHAR_W * CHK_CHARS;
   localparam int unsigned CK_W     = $clog2(CHK_CHARS + 1);
   localparam logic [CK_W-1:0] CK_LAST = CK_W'(CHK_CHARS - 1);

   frm_st_t             st_q;
   logic [CK_W-1:0]     ck_cnt_q;
   logic [CHK_BITS-1:0] ck_sr_q;
   logic [CHK_BITS-1:0] ck_nxt;

   generate
      if (CHK_CHARS == 1) begin : g_ck_one
         assign ck_nxt = char_dat;
      end else begin : g_ck_many
         assign ck_nxt = {char_dat, ck_sr_q[CHK_BITS-1:CHAR_W]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_WAIT;
         ck_cnt_q  <= '0;
         ck_sr_q   <= '0;
         data_out  <= '0;
         data_vld  <= 1'b0;
         frame_end <= 1'b0;
         frame_err <= 1'b0;
         chk_out   <= '0;
         chk_vld   <= 1'b0;
      end else begin
         data_vld  <= 1'b0;
         frame_end <= 1'b0;
         frame_err <= 1'b0;
         chk_vld   <= 1'b0;
         if (flush) begin
            st_q <= ST_WAIT;
         end else if (char_vld) begin
            unique case (st_q)
               ST_WAIT: begin
                  if (char_dat == ESC_CODE) st_q <= ST_WAIT_ESC;
               end
               ST_WAIT_ESC: begin
                  if (char_dat == SOF_CODE)      st_q <= ST_BODY;
                  else if (char_dat != ESC_CODE) st_q <= ST_WAIT;
               end
               ST_BODY: begin
                  if (char_dat == ESC_CODE) begin
                     st_q <= ST_BODY_ESC;
                  end else begin
                     data_out <= char_dat;
                     data_vld <= 1'b1;
                  end
               end
               ST_BODY_ESC: begin
                  if (char_dat == ESC_CODE) begin
                     data_out <= char_dat;
                     data_vld <= 1'b1;
                     st_q     <= ST_BODY;
                  end else if (char_dat == EOF_CODE) begin
                     frame_end <= 1'b1;
                     ck_cnt_q  <= '0;
                     st_q      <= ST_CHECK;
                  end else if (char_dat == SOF_CODE) begin
                     st_q <= ST_BODY;
                  end else begin
                     frame_err <= 1'b1;
                     st_q      <= ST_WAIT;
                  end
               end
               ST_CHECK: begin
                  ck_sr_q <= ck_nxt;
                  if (ck_cnt_q == CK_LAST) begin
                     chk_out <= ck_nxt;
                     chk_vld <= 1'b1;
                     st_q    <= ST_WAIT;
                  end else begin
                     ck_cnt_q <= ck_cnt_q + 1'b1;
                  end
               end
               default: st_q <= ST_WAIT;
            endcase
         end
      end
   end
endmodule

// File: rtl/char_sync_rx.sv
module char_sync_rx #(
   parameter int unsigned CHAR_W    = 8,
   parameter bit          LSB_FIRST = 1'b1,
   parameter int unsigned CHK_CHARS = 2,
   parameter logic [CHAR_W-1:0] SYNC_CODE = 8'h16,
   parameter logic [CHAR_W-1:0] ESC_CODE  = 8'h10,
   parameter logic [CHAR_W-1:0] SOF_CODE  = 8'h02,
   parameter logic [CHAR_W-1:0] EOF_CODE  = 8'h03
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hunt_req,
   input  logic                        bit_en,
   input  logic                        bit_in,
   output logic                        locked,
   output logic [CHAR_W-1:0]           data_out,
   output logic                        data_vld,
   output logic                        frame_end,
   output logic                        frame_err,
   output logic [CHAR_W*CHK_CHARS-1:0] chk_out,
   output logic                        chk_vld
);
   generate
      if (CHAR_W < 3) begin : g_bad_w
         $error("char_sync_rx: CHAR_W must be at least 3");
      end
      if (CHK_CHARS < 1) begin : g_bad_ck
         $error("char_sync_rx: CHK_CHARS must be at least 1");
      end
      if (ESC_CODE == SOF_CODE || ESC_CODE == EOF_CODE || SOF_CODE == EOF_CODE) begin : g_bad_codes
         $error("char_sync_rx: control codes must differ");
      end
   endgenerate

   logic              ch_vld;
   logic [CHAR_W-1:0] ch_dat;

   csr_bit_align #(
      .CHAR_W    (CHAR_W),
      .LSB_FIRST (LSB_FIRST),
      .SYNC_CODE (SYNC_CODE)
   ) u_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .hunt_req (hunt_req),
      .bit_en   (bit_en),
      .bit_in   (bit_in),
      .locked   (locked),
      .char_vld (ch_vld),
      .char_dat (ch_dat)
   );

   csr_deframe #(
      .CHAR_W    (CHAR_W),
      .CHK_CHARS (CHK_CHARS),
      .ESC_CODE  (ESC_CODE),
      .SOF_CODE  (SOF_CODE),
      .EOF_CODE  (EOF_CODE)
   ) u_deframe (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (hunt_req),
      .char_vld  (ch_vld),
      .char_dat  (ch_dat),
      .data_out  (data_out),
      .data_vld  (data_vld),
      .frame_end (frame_end),
      .frame_err (frame_err),
      .chk_out   (chk_out),
      .chk_vld   (chk_vld)
   );
endmodule

// File: rtl/csr_sva.sv
module csr_sva #(
   parameter int unsigned CHAR_W    = 8,
   parameter bit          LSB_FIRST = 1'b1,
   parameter logic [CHAR_W-1:0] SYNC_CODE = 8'h16
) (
   input logic clk,
   input logic rst_n,
   input logic hunt_req,
   input logic bit_en,
   input logic bit_in,
   input logic locked,
   input logic data_vld,
   input logic frame_end,
   input logic frame_err,
   input logic chk_vld
);
   logic [CHAR_W-1:0] shadow_q;
   logic [CHAR_W-1:0] shadow_nxt;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shadow_nxt = {bit_in, shadow_q[CHAR_W-1:1]};
      end else begin : g_msb
         assign shadow_nxt = {shadow_q[CHAR_W-2:0], bit_in};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      shadow_q <= '0;
      else if (bit_en) shadow_q <= shadow_nxt;
   end

   AST_LOCK_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && bit_en && !hunt_req && shadow_nxt == SYNC_CODE) |=> locked); // R1
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !hunt_req) |=> locked); // R2
   AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !(data_vld || frame_end || frame_err || chk_vld)); // R3
   AST_HUNT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_req |=> !locked); // R11
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({data_vld, frame_end, frame_err, chk_vld}) <= 1); // R12
endmodule

bind char_sync_rx csr_sva #(
   .CHAR_W    (CHAR_W),
   .LSB_FIRST (LSB_FIRST),
   .SYNC_CODE (SYNC_CODE)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .hunt_req  (hunt_req),
   .bit_en    (bit_en),
   .bit_in    (bit_in),
   .locked    (locked),
   .data_vld  (data_vld),
   .frame_end (frame_end),
   .frame_err (frame_err),
   .chk_vld   (chk_vld)
);

// File: tb/tb_char_sync_rx.sv
module tb_char_sync_rx;
   localparam int K_DATA = 0, K_END = 1, K_ERR = 2, K_CHK = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hunt_req = 1'b0;
   logic        bit_en = 1'b0;
   logic        bit_in = 1'b1;
   logic        locked;
   logic [7:0]  data_out;
   logic        data_vld, frame_end, frame_err, chk_vld;
   logic [15:0] chk_out;

   int checks = 0;
   int errors = 0;
   logic [17:0] exp_q[$];
   bit done = 1'b0;

   always #2 clk = ~clk;

   char_sync_rx dut (
      .clk(clk), .rst_n(rst_n), .hunt_req(hunt_req), .bit_en(bit_en),
      .bit_in(bit_in), .locked(locked), .data_out(data_out),
      .data_vld(data_vld), .frame_end(frame_end), .frame_err(frame_err),
      .chk_out(chk_out), .chk_vld(chk_vld)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic expect_ev(input int kind, input int val);
      exp_q.push_back({kind[1:0], val[15:0]});
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = b;
      @(negedge clk);
      bit_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] c);
      for (int i = 0; i < 8; i++) send_bit(c[i]);
   endtask

   task automatic pulse_hunt();
      @(negedge clk);
      hunt_req = 1'b1;
      @(negedge clk);
      hunt_req = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (data_vld || frame_end || frame_err || chk_vld)) begin
         int kind;
         int val;
         logic [17:0] e;
         kind = data_vld ? K_DATA : frame_end ? K_END : frame_err ? K_ERR : K_CHK;
         val  = data_vld ? int'(data_out) : chk_vld ? int'(chk_out) : 0;
         if (exp_q.size() == 0) begin
            check(1'b0, "R3/R4/R9 unexpected output", kind * 65536 + val, 0);
         end else begin
            e = exp_q.pop_front();
            check(e == {kind[1:0], val[15:0]}, "R5-R10 scoreboard event",
                  kind * 65536 + val, int'(e));
         end
      end
   end

   initial begin
      #700000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(locked == 1'b0, "R3 reset locked", locked, 0);
      check(!(data_vld || frame_end || frame_err || chk_vld), "R3 reset strobes", data_vld, 0);

      // R3: start pair while unlocked gives nothing
      send_char(8'hFF);
      send_char(8'h10);
      send_char(8'h02);
      check(locked == 1'b0, "R3 no lock before sync", locked, 0);

      // R1: three pad bits shift the boundary, then sync
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      send_char(8'h16);
      check(locked == 1'b1, "R1 lock after sync", locked, 1);

      // R4: fill between frames
      send_char(8'h16); send_char(8'h16); send_char(8'h55);
      // R5 R6 R7 R8 frame
      expect_ev(K_DATA, 'h41);
      expect_ev(K_DATA, 'h16);
      expect_ev(K_DATA, 'h10);  // R6
      expect_ev(K_DATA, 'h03);
      expect_ev(K_END, 0);      // R7
      expect_ev(K_CHK, 'h3CA5); // R8
      send_char(8'h10); send_char(8'h02);
      send_char(8'h41); send_char(8'h16);
      send_char(8'h10); send_char(8'h10);
      send_char(8'h03);
      send_char(8'h10); send_char(8'h03);
      send_char(8'hA5); send_char(8'h3C);
      check(locked == 1'b1, "R2 lock holds", locked, 1);

      // R9: undefined escape aborts
      expect_ev(K_DATA, 'h22);
      expect_ev(K_ERR, 0);
      send_char(8'h16);
      send_char(8'h10); send_char(8'h02);
      send_char(8'h22);
      send_char(8'h10); send_char(8'h47);
      send_char(8'h33);

      // R10: start pair inside a body restarts
      expect_ev(K_DATA, 'h44);
      expect_ev(K_DATA, 'h55);
      expect_ev(K_END, 0);
      expect_ev(K_CHK, 'h0201);
      send_char(8'h10); send_char(8'h02);
      send_char(8'h44);
      send_char(8'h10); send_char(8'h02);
      send_char(8'h55);
      send_char(8'h10); send_char(8'h03);
      send_char(8'h01); send_char(8'h02);

      // R11: hunt in mid-frame
      expect_ev(K_DATA, 'h12);
      send_char(8'h10); send_char(8'h02);
      send_char(8'h12);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      pulse_hunt();
      check(locked == 1'b0, "R11 hunt clears lock", locked, 0);
      send_char(8'h10); send_char(8'h02); send_char(8'h66);
      check(locked == 1'b0, "R11 stays hunting", locked, 0);

      // R1 R2: relock on a new boundary
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      send_char(8'h16);
      check(locked == 1'b1, "R1 relock after hunt", locked, 1);
      expect_ev(K_DATA, 'h77);
      expect_ev(K_END, 0);
      expect_ev(K_CHK, 'h0000);
      send_char(8'h10); send_char(8'h02);
      send_char(8'h77);
      send_char(8'h10); send_char(8'h03);
      send_char(8'h00); send_char(8'h00);

      repeat (6) @(negedge clk);
      check(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule